// File: doc/BRIEF.md
# Bus-Master DMA Register Port

This block serves the register side of a two-channel disk controller's bus-master DMA unit. It decodes a 16-byte I/O window in which each channel owns a 4-byte register area, channel 0 at offset 0 and channel 1 at offset 8. The 4-byte descriptor-address area that follows each register area, at offset +4, is decoded as a miss. Within a register area the two low address bits pick one of four bytes: offset 0 is the channel command byte, offset 1 is a window onto the controller-wide mode register, offset 2 is the channel status byte and offset 3 is the channel timing byte.

The command and timing bytes are stored here and driven out to the DMA engine and the drive-timing logic. The shared mode register lives in a neighbouring interrupt bank. This block reads that register live. When software writes offset 1, the block returns a full replacement byte in which only the two interrupt-blocking bits have changed. The status byte mixes three kinds of field. The active flag is set and cleared only by the engine. The error and interrupt flags are set by the engine and cleared by writing ones. The two capability bits are plain read/write.

Top module: `bm_reg_port`

## Requirements
- R1: A read whose size code is not byte (acc_size 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes) returns all ones for its width: 0x0000FFFF for 2 bytes and 0xFFFFFFFF for 4 bytes.
- R2: A write whose size is not one byte changes no stored byte and raises no mode write.
- R3: acc_addr[3] selects the channel and acc_addr[1:0] selects the byte (0 command, 1 mode, 2 status, 3 timing). An access with acc_addr[2] set falls in the descriptor-address area: a read returns 0xFF and a write changes nothing.
- R4: The command byte of each channel is a full 8-bit read/write byte, reset to 0, and is driven on cmd_out (channel 1 in bits 15:8).
- R5: A byte read at offset 1 of either channel returns mode_in unchanged.
- R6: A byte write at offset 1 of either channel pulses mode_wr_en in the same cycle, with mode_wr_data equal to mode_in except that bits 5:4 take the written value.
- R7: A status write loads bits 6:5 from the data, keeps bit 0, and forces bits 7, 4 and 3 to zero.
- R8: Status bits 2 (interrupt) and 1 (error) are cleared where the written status byte has a one and are kept where it has a zero.
- R9: ev_err_set and ev_irq_set set status bits 1 and 2 of their channel. A set takes priority over a write-one-to-clear of the same bit in the same cycle.
- R10: Status bit 0 is set by ev_act_set and cleared by ev_act_clr, with set winning when both occur. A status write does not change it.
- R11: Each channel has its own 8-bit timing byte at offset 3, reset to 0 and driven on timing_out (channel 1 in bits 15:8).
- R12: After reset, every command, status and timing byte reads 0 and mode_wr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset within the window |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| acc_wdata | input | 8 | Write byte |
| rdata | output | 32 | Read data for the current address and size |
| mode_in | input | 8 | Live shared mode register from the interrupt bank |
| mode_wr_en | output | 1 | Replace the shared mode register this cycle |
| mode_wr_data | output | 8 | Replacement value for the shared mode register |
| ev_act_set | input | 2 | Per channel: engine became active |
| ev_act_clr | input | 2 | Per channel: engine went idle |
| ev_err_set | input | 2 | Per channel: transfer error |
| ev_irq_set | input | 2 | Per channel: interrupt condition |
| cmd_out | output | 16 | Command bytes, channel 1 in the high byte |
| timing_out | output | 16 | Timing bytes, channel 1 in the high byte |

## Verification
The hardest case to reach is the collision between an engine event and a software write-one-to-clear on the same status bit in the same clock. Only in that cycle does the set-over-clear priority show. The bench drives ev_err_set in the same cycle as a status write that has bit 1 set. It then reads the status back and expects the error flag to be still set. A second write without the event must then clear it. The active flag is covered in a similar way: it is raised by an event, and a status write with bit 0 at zero must leave it set.

// File: rtl/bm_pkg.sv
// Shared encodings for the bus-master register port.
// Assumes a 16-byte window with two channels at a stride of 8 bytes.
package bm_pkg;

    // Byte selected by the two low address bits inside a register area
    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STS  = 2'd2,
        SEL_TIM  = 2'd3
    } bm_sel_e;

    // Status bit positions
    localparam int STS_ACT   = 0;
    localparam int STS_ERR   = 1;
    localparam int STS_IRQ   = 2;
    localparam int STS_CAP_L = 5;
    localparam int STS_CAP_H = 6;

    // Address bit that marks the descriptor-address area
    localparam int DESC_BIT  = 2;

    // Shared mode register bits owned by this port
    localparam logic [7:0] MODE_BLK_MASK = 8'h30;

endpackage

// File: rtl/bm_decode.sv
// Address and size decoder. It turns one access into per-channel write
// strobes plus the channel and byte select used by the read mux.
// Assumes the channel index sits directly above the descriptor bit.
module bm_decode
    import bm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_size,
    output logic              byte_ok,
    output logic              desc_hit,
    output logic [CH_W-1:0]   chan,
    output bm_sel_e           sel,
    output logic [NUM_CH-1:0] cmd_we,
    output logic [NUM_CH-1:0] sts_we,
    output logic [NUM_CH-1:0] tim_we,
    output logic              mode_we
);

    logic wr_hit;

    // Field extraction from the address and size
    always_comb begin
        byte_ok  = (acc_size == 2'd0);
        desc_hit = acc_addr[DESC_BIT];
        chan     = acc_addr[ADDR_W-1 -: CH_W];
        sel      = bm_sel_e'(acc_addr[1:0]);
        wr_hit   = acc_valid && acc_write && byte_ok && !desc_hit;
        mode_we  = wr_hit && (sel == SEL_MODE);
    end

    // Per-channel write strobes
    for (genvar c = 0; c < NUM_CH; c++) begin : g_strb
        always_comb begin
            cmd_we[c] = wr_hit && (chan == CH_W'(c)) && (sel == SEL_CMD);
            sts_we[c] = wr_hit && (chan == CH_W'(c)) && (sel == SEL_STS);
            tim_we[c] = wr_hit && (chan == CH_W'(c)) && (sel == SEL_TIM);
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_we, sts_we, tim_we, mode_we})); // R3
    AST_WIDE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_size != 2'd0) |-> ({cmd_we, sts_we, tim_we, mode_we} == '0)); // R2
    AST_DESC_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_addr[DESC_BIT]) |-> ({cmd_we, sts_we, tim_we, mode_we} == '0)); // R3

endmodule

// File: rtl/bm_chan.sv
// One channel's stored bytes: command, status and timing.
// Status mixes an engine-owned active flag, engine-set flags that are
// cleared by writing ones (sets win), and two read/write bits.
module bm_chan
    import bm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] wdata,
    input  logic       cmd_we,
    input  logic       sts_we,
    input  logic       tim_we,
    input  logic       ev_act_set,
    input  logic       ev_act_clr,
    input  logic       ev_err_set,
    input  logic       ev_irq_set,
    output logic [7:0] cmd_q,
    output logic [7:0] sts_q,
    output logic [7:0] tim_q
);

    logic [7:0] sts_d;

    // Next status: software write first, then engine events on top
    always_comb begin
        sts_d = sts_q;
        if (sts_we) begin
            sts_d                     = 8'h00;
            sts_d[STS_CAP_H:STS_CAP_L] = wdata[STS_CAP_H:STS_CAP_L];
            sts_d[STS_IRQ:STS_ERR]     = sts_q[STS_IRQ:STS_ERR] & ~wdata[STS_IRQ:STS_ERR];
            sts_d[STS_ACT]            = sts_q[STS_ACT];
        end
        if (ev_err_set) sts_d[STS_ERR] = 1'b1;
        if (ev_irq_set) sts_d[STS_IRQ] = 1'b1;
        if (ev_act_clr) sts_d[STS_ACT] = 1'b0;
        if (ev_act_set) sts_d[STS_ACT] = 1'b1;
    end

    // Register update for all three bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= 8'h00;
            sts_q <= 8'h00;
            tim_q <= 8'h00;
        end else begin
            if (cmd_we) cmd_q <= wdata;
            if (tim_we) tim_q <= wdata;
            sts_q <= sts_d;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q)); // R4
    AST_TIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tim_we |=> $stable(tim_q)); // R11
    AST_ERR_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err_set |=> sts_q[STS_ERR]); // R9
    AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && wdata[STS_ERR] && !ev_err_set) |=> !sts_q[STS_ERR]); // R8
    AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sts_we && !ev_irq_set) |=> $stable(sts_q[STS_IRQ])); // R8
    AST_ACT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_act_set && !ev_act_clr) |=> $stable(sts_q[STS_ACT])); // R10

endmodule

// File: rtl/bm_reg_port.sv
// Bus-master register port for two channels. It decodes the 16-byte
// window, holds per-channel bytes, reads the shared mode register live
// and returns a replacement byte when the blocking bits are written.
// Assumes reads are combinational from the current address and size.
module bm_reg_port
    import bm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_size,
    input  logic [7:0]          acc_wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [7:0]          mode_in,
    output logic                mode_wr_en,
    output logic [7:0]          mode_wr_data,
    input  logic [NUM_CH-1:0]   ev_act_set,
    input  logic [NUM_CH-1:0]   ev_act_clr,
    input  logic [NUM_CH-1:0]   ev_err_set,
    input  logic [NUM_CH-1:0]   ev_irq_set,
    output logic [NUM_CH*8-1:0] cmd_out,
    output logic [NUM_CH*8-1:0] timing_out
);

    logic              byte_ok;
    logic              desc_hit;
    logic [CH_W-1:0]   chan;
    bm_sel_e           sel;
    logic [NUM_CH-1:0] cmd_we, sts_we, tim_we;
    logic              mode_we;
    logic [7:0]        cmd_q [NUM_CH];
    logic [7:0]        sts_q [NUM_CH];
    logic [7:0]        tim_q [NUM_CH];
    logic [7:0]        rd_byte;
    logic [DATA_W-1:0] ones;

    bm_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .acc_size (acc_size),
        .byte_ok  (byte_ok),
        .desc_hit (desc_hit),
        .chan     (chan),
        .sel      (sel),
        .cmd_we   (cmd_we),
        .sts_we   (sts_we),
        .tim_we   (tim_we),
        .mode_we  (mode_we)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bm_chan u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wdata     (acc_wdata),
            .cmd_we    (cmd_we[c]),
            .sts_we    (sts_we[c]),
            .tim_we    (tim_we[c]),
            .ev_act_set(ev_act_set[c]),
            .ev_act_clr(ev_act_clr[c]),
            .ev_err_set(ev_err_set[c]),
            .ev_irq_set(ev_irq_set[c]),
            .cmd_q     (cmd_q[c]),
            .sts_q     (sts_q[c]),
            .tim_q     (tim_q[c])
        );
        assign cmd_out[c*8 +: 8]    = cmd_q[c];
        assign timing_out[c*8 +: 8] = tim_q[c];
    end

    // Mode write-back: replace only the blocking bits
    always_comb begin
        mode_wr_en   = mode_we;
        mode_wr_data = (mode_in & ~MODE_BLK_MASK) | (acc_wdata & MODE_BLK_MASK);
    end

    // Read mux: width-sized all-ones for wide accesses, byte otherwise
    always_comb begin
        case (acc_size)
            2'd0:    ones = DATA_W'(8'hFF);
            2'd1:    ones = DATA_W'(16'hFFFF);
            default: ones = '1;
        endcase
        case (sel)
            SEL_CMD:  rd_byte = cmd_q[chan];
            SEL_MODE: rd_byte = mode_in;
            SEL_STS:  rd_byte = sts_q[chan];
            default:  rd_byte = tim_q[chan];
        endcase
        if (!byte_ok || desc_hit) rdata = ones;
        else                      rdata = DATA_W'(rd_byte);
    end

    AST_MODE_KEEP_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |-> ((mode_wr_data & ~MODE_BLK_MASK) == (mode_in & ~MODE_BLK_MASK))); // R6
    AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |-> (acc_valid && acc_write && acc_size == 2'd0)); // R2
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (cmd_out == '0 && timing_out == '0)); // R12

endmodule

// File: tb/bm_reg_port_tb.sv
module bm_reg_port_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write;
    logic [3:0]  acc_addr;
    logic [1:0]  acc_size;
    logic [7:0]  acc_wdata;
    logic [31:0] rdata;
    logic [7:0]  mode_in;
    logic        mode_wr_en;
    logic [7:0]  mode_wr_data;
    logic [1:0]  ev_act_set, ev_act_clr, ev_err_set, ev_irq_set;
    logic [15:0] cmd_out, timing_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    bm_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .rdata(rdata), .mode_in(mode_in), .mode_wr_en(mode_wr_en),
        .mode_wr_data(mode_wr_data), .ev_act_set(ev_act_set),
        .ev_act_clr(ev_act_clr), .ev_err_set(ev_err_set), .ev_irq_set(ev_irq_set),
        .cmd_out(cmd_out), .timing_out(timing_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] sz, output logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #1 d = rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // Write; mode_wr_en/data are sampled in the access cycle
    task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [7:0] v,
                      output logic m_en, output logic [7:0] m_d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = v;
        #1 m_en = mode_wr_en; m_d = mode_wr_data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic wr0(input logic [3:0] a, input logic [7:0] v);
        logic e; logic [7:0] d;
        wr(a, 2'd0, v, e, d);
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, 2'd0, d);
        chk(req, d, exp);
    endtask

    task automatic t_reset;
        chk("R12 mode_wr_en idle", {31'd0, mode_wr_en}, 32'd0);
        rdchk("R12 cmd ch0", 4'h0, 32'h00);
        rdchk("R12 sts ch1", 4'hA, 32'h00);
        rdchk("R12 tim ch1", 4'hB, 32'h00);
        chk("R12 cmd_out", {16'd0, cmd_out}, 32'h0);
    endtask

    task automatic t_cmd;
        wr0(4'h0, 8'hA5);
        wr0(4'h8, 8'h3C);
        rdchk("R4 cmd ch0", 4'h0, 32'hA5);
        rdchk("R3 cmd ch1", 4'h8, 32'h3C);
        chk("R4 cmd_out", {16'd0, cmd_out}, 32'h3CA5);
    endtask

    task automatic t_mode;
        logic e; logic [7:0] d;
        mode_in = 8'hC7;
        rdchk("R5 mode ch0", 4'h1, 32'hC7);
        rdchk("R5 mode ch1", 4'h9, 32'hC7);
        wr(4'h9, 2'd0, 8'hFF, e, d);
        chk("R6 mode_wr_en", {31'd0, e}, 32'd1);
        chk("R6 mode data set", {24'd0, d}, 32'hF7);
        mode_in = 8'hFF;
        wr(4'h1, 2'd0, 8'h00, e, d);
        chk("R6 mode data clr", {24'd0, d}, 32'hCF);
        chk("R6 cmd untouched", {16'd0, cmd_out}, 32'h3CA5);
    endtask

    task automatic t_status;
        wr0(4'h2, 8'hFF);
        rdchk("R7 sts caps", 4'h2, 32'h60);
        @(negedge clk); ev_act_set = 2'b01;
        @(negedge clk); ev_act_set = 2'b00;
        wr0(4'h2, 8'h00);
        rdchk("R10 act kept by write", 4'h2, 32'h01);
    endtask

    task automatic t_w1c;
        @(negedge clk); ev_err_set = 2'b10; ev_irq_set = 2'b10;
        @(negedge clk); ev_err_set = 2'b00; ev_irq_set = 2'b00;
        rdchk("R9 ch1 flags set", 4'hA, 32'h06);
        wr0(4'hA, 8'h02);
        rdchk("R8 clear err only", 4'hA, 32'h04);
        wr0(4'hA, 8'h04);
        rdchk("R8 clear irq", 4'hA, 32'h00);
    endtask

    task automatic t_priority;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'h2; acc_size = 2'd0;
        acc_wdata = 8'h02; ev_err_set = 2'b01;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; ev_err_set = 2'b00;
        rdchk("R9 set beats clear", 4'h2, 32'h03);
        wr0(4'h2, 8'h06);
        rdchk("R8 clear after", 4'h2, 32'h01);
        @(negedge clk); ev_act_clr = 2'b01;
        @(negedge clk); ev_act_clr = 2'b00;
        rdchk("R10 act cleared", 4'h2, 32'h00);
    endtask

    task automatic t_timing;
        wr0(4'h3, 8'h11);
        wr0(4'hB, 8'h22);
        rdchk("R11 tim ch0", 4'h3, 32'h11);
        rdchk("R11 tim ch1", 4'hB, 32'h22);
        chk("R11 timing_out", {16'd0, timing_out}, 32'h2211);
    endtask

    task automatic t_wide;
        logic [31:0] d; logic e; logic [7:0] md;
        rd(4'h0, 2'd1, d);
        chk("R1 half read", d, 32'h0000FFFF);
        rd(4'h0, 2'd2, d);
        chk("R1 word read", d, 32'hFFFFFFFF);
        wr(4'h0, 2'd2, 8'h00, e, md);
        wr(4'h9, 2'd1, 8'h00, e, md);
        chk("R2 no mode write", {31'd0, e}, 32'd0);
        wr(4'hB, 2'd1, 8'h00, e, md);
        chk("R2 cmd kept", {16'd0, cmd_out}, 32'h3CA5);
        chk("R2 timing kept", {16'd0, timing_out}, 32'h2211);
    endtask

    task automatic t_desc;
        rdchk("R3 desc read", 4'h4, 32'hFF);
        wr0(4'h4, 8'h00);
        wr0(4'hC, 8'h00);
        wr0(4'hF, 8'h00);
        chk("R3 desc write cmd", {16'd0, cmd_out}, 32'h3CA5);
        chk("R3 desc write tim", {16'd0, timing_out}, 32'h2211);
    endtask

    initial begin
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_addr = '0;
        acc_size = '0; acc_wdata = '0; mode_in = 8'h00;
        ev_act_set = '0; ev_act_clr = '0; ev_err_set = '0; ev_irq_set = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cmd();
        t_mode();
        t_status();
        t_w1c();
        t_priority();
        t_timing();
        t_wide();
        t_desc();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule